// File: doc/BRIEF.md
# Conditional Branch and Loop Evaluator

This block decides, for one branch-class operation at a time, whether control flow is redirected. It takes an operation code, five status flags and a 16-bit count register value. It returns a taken indication, the count value to write back together with a write enable, and a byte result for conditional-set operations. The operation codes cover two groups. The first group holds sixteen flag-tested conditions, including signed and unsigned magnitude comparisons. The second group holds four count-based forms: jump when the count is zero, plain loop, loop while equal, and loop while not equal.

Each operation is presented with `in_valid` for one cycle. The registered result appears on the outputs on the following cycle, qualified by `out_valid`. Flags are never modified by any operation. The count is written back only by the three loop forms. Target address arithmetic is not part of this block; the surrounding fetch logic uses `taken` to pick the next address.

Flag vector layout: bit 0 carry (C), bit 1 parity (P), bit 2 zero (Z), bit 3 sign (S), bit 4 overflow (O).

Top module: `cond_branch_eval`

## Requirements
- R1: When `op[4]`=0, `op[3:1]` selects a base condition, in order: 0 O, 1 C, 2 Z, 3 C|Z, 4 S, 5 P, 6 S!=O, 7 Z|(S!=O). `taken` equals that base condition XOR `op[0]`. These codes never assert `count_we`.
- R2: The unsigned codes are: above = 7 (!C&!Z), below-or-equal = 6, below = 2 (C), above-or-equal = 3 (!C). After an 8-bit subtraction a-b, above is true exactly when a>b unsigned and below exactly when a<b unsigned (FFH is above 00H).
- R3: The signed codes are: less = 12 (S!=O), greater-or-equal = 13, less-or-equal = 14, greater = 15 (!Z&(S==O)). After an 8-bit subtraction a-b, they agree with the signed comparison of a and b (FFH is less than 00H).
- R4: Code 16 (count-zero jump) is taken exactly when the count is 0000H. It deasserts `count_we` and returns the count unchanged on `count_out`.
- R5: Code 17 (loop) asserts `count_we`, returns count-1 modulo 2^16, and is taken only when that value is nonzero. A count of 0000H gives FFFFH and is taken.
- R6: Code 18 (loop while equal) decrements like R5. It is taken only when the new count is nonzero and Z=1.
- R7: Code 19 (loop while not equal) decrements like R5. It is taken only when the new count is nonzero and Z=0.
- R8: `set_byte` is 01H when the operation is taken and 00H otherwise.
- R9: Each odd code 2k+1 in the flag group is the exact complement of code 2k. Two names for one condition (equal/zero, above/not-below-or-equal) share one code and behave identically.
- R10: Codes 20 to 31 are never taken, never write the count, give `set_byte` 00H and return the count unchanged.
- R11: Results appear one cycle after `in_valid` with `out_valid`=1. While `out_valid`=0, `taken`, `count_we` and `set_byte` are 0.
- R12: After reset, `out_valid`, `taken`, `count_we`, `count_out` and `set_byte` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code |
| flags | input | 5 | Status flags {O,S,Z,P,C} |
| count_in | input | 16 | Current count register |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch redirects flow |
| count_we | output | 1 | Write `count_out` back to the count register |
| count_out | output | 16 | Count value after the operation |
| set_byte | output | 8 | Conditional-set result, 01H or 00H |

## Verification
The bench sweeps every code against every flag pattern and a set of count values that includes the wrap points 0000H, 0001H and FFFFH. A design that tested the old count instead of the decremented count would take a loop at count 0001H and skip it at 0000H. A design that reused the unsigned tests for the signed codes would get FFH versus 00H wrong. The bench therefore derives the flags from real 8-bit subtractions and compares every magnitude code against integer comparisons. It also confirms that count-zero jumps and the reserved codes leave the count alone, and that complement pairs never agree.

// File: rtl/cond_branch_eval.sv
module cond_branch_eval #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [4:0]       op,
  input  logic [4:0]       flags,
  input  logic [CNT_W-1:0] count_in,
  output logic             out_valid,
  output logic             taken,
  output logic             count_we,
  output logic [CNT_W-1:0] count_out,
  output logic [7:0]       set_byte
);
  localparam logic [4:0] OP_CZ     = 5'd16;
  localparam logic [4:0] OP_LOOP   = 5'd17;
  localparam logic [4:0] OP_LOOPEQ = 5'd18;
  localparam logic [4:0] OP_LOOPNE = 5'd19;

  logic fc, fp, fz, fs, fo;
  assign {fo, fs, fz, fp, fc} = flags;

  logic [7:0] base;
  assign base = {fz | (fs ^ fo), fs ^ fo, fp, fs, fc | fz, fz, fc, fo};

  logic flag_true;
  assign flag_true = base[op[3:1]] ^ op[0];

  logic [CNT_W-1:0] cnt_dec;
  logic cnt_nz, cnt_zero;
  assign cnt_dec  = count_in - CNT_W'(1);
  assign cnt_nz   = |cnt_dec;
  assign cnt_zero = ~|count_in;

  logic take, we;
  always_comb begin
    take = 1'b0;
    we   = 1'b0;
    if (!op[4]) take = flag_true;
    else begin
      case (op)
        OP_CZ:     take = cnt_zero;
        OP_LOOP:   begin we = 1'b1; take = cnt_nz; end
        OP_LOOPEQ: begin we = 1'b1; take = cnt_nz & fz; end
        OP_LOOPNE: begin we = 1'b1; take = cnt_nz & ~fz; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      count_we  <= 1'b0;
      count_out <= '0;
      set_byte  <= 8'h00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken     <= take;
        count_we  <= we;
        count_out <= we ? cnt_dec : count_in;
        set_byte  <= take ? 8'h01 : 8'h00;
      end else begin
        taken    <= 1'b0;
        count_we <= 1'b0;
        set_byte <= 8'h00;
      end
    end
  end

  assert_flag_codes_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !op[4] |=> !count_we);
  assert_cz_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_CZ |=> !count_we && count_out == $past(count_in));
  assert_loop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_LOOP |=> count_we && count_out == CNT_W'($past(count_in) - CNT_W'(1)));
  assert_loopeq_needs_z_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_LOOPEQ && !flags[2] |=> !taken);
  assert_loopne_needs_nz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_LOOPNE && flags[2] |=> !taken);
  assert_set_matches_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> set_byte == {7'b0, taken});
  assert_reserved_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op[4] && op[3:2] != 2'b00 |=> !taken && !count_we);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !taken && !count_we && set_byte == 8'h00);
endmodule

// File: tb/test_cond_branch_eval.sv
module test_cond_branch_eval;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [4:0] op = '0;
  logic [4:0] flags = '0;
  logic [CW-1:0] count_in = '0;
  logic out_valid, taken, count_we;
  logic [CW-1:0] count_out;
  logic [7:0] set_byte;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_branch_eval #(.CNT_W(CW)) i_cond_branch_eval (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .flags(flags),
    .count_in(count_in), .out_valid(out_valid), .taken(taken),
    .count_we(count_we), .count_out(count_out), .set_byte(set_byte));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s op=%0d flags=%b cnt=%h act=%h exp=%h", req, op, flags, count_in, act, exp);
    end
  endtask

  function automatic bit cond_of(input int code, input logic [4:0] f);
    bit c, p, z, s, o, r;
    c = f[0]; p = f[1]; z = f[2]; s = f[3]; o = f[4];
    case (code)
      0: r = o;            1: r = !o;
      2: r = c;            3: r = !c;
      4: r = z;            5: r = !z;
      6: r = c || z;       7: r = !c && !z;
      8: r = s;            9: r = !s;
      10: r = p;           11: r = !p;
      12: r = (s != o);    13: r = (s == o);
      14: r = z || (s != o);
      default: r = !z && (s == o);
    endcase
    return r;
  endfunction

  task automatic apply(input logic [4:0] o, input logic [4:0] f, input logic [CW-1:0] c);
    @(negedge clk);
    op = o; flags = f; count_in = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [CW-1:0] cnts [6];
    cnts[0] = 16'h0000; cnts[1] = 16'h0001; cnts[2] = 16'h0002;
    cnts[3] = 16'h8000; cnts[4] = 16'hFFFF; cnts[5] = 16'h1234;

    repeat (3) @(negedge clk);
    check("R12 out_valid", out_valid, 0);
    check("R12 taken", taken, 0);
    check("R12 count_we", count_we, 0);
    check("R12 count_out", count_out, 0);
    check("R12 set_byte", set_byte, 0);
    rst_n = 1'b1;

    for (int code = 0; code < 32; code++) begin
      for (int f = 0; f < 32; f++) begin
        for (int k = 0; k < 6; k++) begin
          logic [CW-1:0] c, dec;
          bit et, ew;
          logic [CW-1:0] ec;
          c = cnts[k];
          dec = c - 16'd1;
          ew = 0; ec = c;
          if (code < 16) et = cond_of(code, 5'(f));
          else if (code == 16) et = (c == 0);
          else if (code == 17) begin ew = 1; ec = dec; et = (dec != 0); end
          else if (code == 18) begin ew = 1; ec = dec; et = (dec != 0) && f[2]; end
          else if (code == 19) begin ew = 1; ec = dec; et = (dec != 0) && !f[2]; end
          else et = 0;
          apply(5'(code), 5'(f), c);
          check("R11 out_valid", out_valid, 1);
          if (code < 16) begin
            check("R1 taken", taken, et);
            check("R1 no write", count_we, 0);
          end else if (code == 16) begin
            check("R4 taken", taken, et);
            check("R4 no write", count_we, 0);
            check("R4 count", count_out, ec);
          end else if (code == 17) begin
            check("R5 taken", taken, et);
            check("R5 write", count_we, 1);
            check("R5 count", count_out, ec);
          end else if (code == 18) begin
            check("R6 taken", taken, et);
            check("R6 count", count_out, ec);
          end else if (code == 19) begin
            check("R7 taken", taken, et);
            check("R7 count", count_out, ec);
          end else begin
            check("R10 taken", taken, 0);
            check("R10 no write", count_we, 0);
            check("R10 count", count_out, c);
          end
          check("R8 set_byte", set_byte, et ? 8'h01 : 8'h00);
        end
      end
    end

    // R9: complement pairs never agree
    for (int f = 0; f < 32; f++) begin
      for (int k = 0; k < 8; k++) begin
        logic t0;
        apply(5'(2*k), 5'(f), 16'h0005);
        t0 = taken;
        apply(5'(2*k+1), 5'(f), 16'h0005);
        check("R9 complement", taken, !t0);
      end
    end

    // R2 / R3: flags from real 8-bit subtraction
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 15) begin
        logic [8:0] d;
        logic [4:0] fl;
        logic [7:0] r;
        d = {1'b0, 8'(a)} - {1'b0, 8'(b)};
        r = d[7:0];
        fl[0] = d[8];
        fl[1] = ~^r;
        fl[2] = (r == 0);
        fl[3] = r[7];
        fl[4] = (a[7] != b[7]) && (r[7] != a[7]);
        apply(5'd7, fl, 16'h0003);  check("R2 above", taken, a > b);
        apply(5'd2, fl, 16'h0003);  check("R2 below", taken, a < b);
        apply(5'd12, fl, 16'h0003); check("R3 less", taken, $signed(8'(a)) < $signed(8'(b)));
        apply(5'd15, fl, 16'h0003); check("R3 greater", taken, $signed(8'(a)) > $signed(8'(b)));
        apply(5'd14, fl, 16'h0003); check("R3 less-or-equal", taken, $signed(8'(a)) <= $signed(8'(b)));
      end
    end

    // explicit FFH versus 00H
    apply(5'd7, 5'b01000, 16'h0003);  check("R2 FF above 00", taken, 1);
    apply(5'd12, 5'b01000, 16'h0003); check("R3 FF less 00", taken, 1);

    @(negedge clk);
    check("R11 idle taken", taken, 0);
    check("R11 idle we", count_we, 0);
    check("R11 idle valid", out_valid, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule